// File: doc/BRIEF.md
# Word-Serial Coefficient and Control Register Loader

This block turns a narrow stream of 12-bit words into wide, atomic writes for a filter's coefficient memory and control register files. A host holds an active-low load strobe low and presents one word per clock. The first word of each transaction names a target class and an entry index. The loader then gathers as many data words as that class needs. On the clock edge that takes in the final word it commits one write, and presents that write as a registered strobe with its index and its assembled data.

Coefficient sets fill one row across all eight banks at once. Configuration words and 5-bit select words take a single data word each. Round and limit values are 32 bits wide and arrive as four bytes, least significant byte first. A pause input freezes the sequence without losing progress, so the host may feed words slower than the clock. Raising the load strobe ends the session. The storage behind the strobes is outside this block.

Top module: `wordser_loader`

## Requirements
- R1: After reset every write strobe is low and every index and data output is zero. A session opens only on a high-to-low change of `ld_n` that the loader samples after reset, so holding `ld_n` low straight out of reset loads nothing.
- R2: The edge that samples the opening low level of `ld_n` captures the address word. Address bits 11:9 select the class: 000 coefficient, 001 configuration, 011 select, 101 round, 111 limit. Bits 8:0 carry the index. The coefficient row takes bits 7:0, the configuration index bits 1:0, and select, round and limit indices bits 3:0.
- R3: A coefficient transaction takes eight data words. The k-th data word goes to bank k, at `coef_data[12k+11:12k]`. Back-to-back sets cost 9 cycles each.
- R4: Configuration and select transactions take one data word. `cfg_data` is the whole 12-bit word and `sel_data` is its bits 4:0.
- R5: Round and limit transactions take four data words. Bits 7:0 of data word j land in bits 8j+7:8j of the 32-bit value, and bits 11:8 of each data word are ignored. For a limit value, bits 15:0 hold the lower bound and bits 31:16 the upper bound. Back-to-back registers cost 5 cycles each.
- R6: A write strobe rises only in the cycle after the edge that captures a transaction's final data word. It is high for exactly one cycle, and no strobe appears for earlier words.
- R7: Once a transaction completes, the next word captured while `ld_n` stays low is a new address.
- R8: On an edge where `pause` is high, the bus is ignored and the word count and partial data are held. Loading resumes at the same word once `pause` is low. No strobe follows a paused edge.
- R9: Sampling `ld_n` high abandons any partial transaction without a write. The next session starts again with an address word.
- R10: The unused class codes 010, 100 and 110 consume the address word plus one data word, and write nothing.
- R11: At most one strobe is high in any cycle. Each index and data output holds its value between its own strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Load strobe, active low |
| pause | input | 1 | Freeze the loading sequence while high |
| din | input | 12 | Serial address or data word |
| coef_we | output | 1 | Coefficient row write strobe |
| coef_row | output | 8 | Coefficient row index |
| coef_data | output | 96 | Eight 12-bit coefficients, bank 0 in the low bits |
| cfg_we | output | 1 | Configuration register write strobe |
| cfg_idx | output | 2 | Configuration register index |
| cfg_data | output | 12 | Configuration register value |
| sel_we | output | 1 | Select register write strobe |
| sel_idx | output | 4 | Select register index |
| sel_data | output | 5 | Select register value |
| rnd_we | output | 1 | Round register write strobe |
| rnd_idx | output | 4 | Round register index |
| rnd_data | output | 32 | Round register value |
| lim_we | output | 1 | Limit register write strobe |
| lim_idx | output | 4 | Limit register index |
| lim_data | output | 32 | Limit value, upper bound 31:16 and lower bound 15:0 |

## Verification
Every write is due in the cycle after the edge that captures its final data word, and is observable for exactly that one cycle. The bench therefore drives each word just after a rising edge and samples one nanosecond after the next edge. The strobe, index and data are read after the final word. After intermediate, paused, abandoned or unused-class words the bench checks instead that every strobe is still low. Full sweeps of all 256 coefficient rows and all 16 select, round and limit registers run back to back in one session. This confirms the 9-cycle and 5-cycle spacing and that each address follows straight after the previous transaction.

// File: rtl/wsl_pkg.sv
`timescale 1ns/1ps
package wsl_pkg;
  localparam logic [2:0] CLS_COEF = 3'b000;
  localparam logic [2:0] CLS_CFG  = 3'b001;
  localparam logic [2:0] CLS_SEL  = 3'b011;
  localparam logic [2:0] CLS_RND  = 3'b101;
  localparam logic [2:0] CLS_LIM  = 3'b111;

  // number of data words that follow an address of the given class
  function automatic int unsigned data_words(input logic [2:0] cls,
                                             input int unsigned nbank,
                                             input int unsigned wide_words);
    case (cls)
      CLS_COEF:         return nbank;
      CLS_RND, CLS_LIM: return wide_words;
      default:          return 1;
    endcase
  endfunction
endpackage

// File: rtl/wsl_seq.sv
`timescale 1ns/1ps
module wsl_seq #(
  parameter int DW         = 12,
  parameter int NBANK      = 8,
  parameter int WIDE_WORDS = 4,
  parameter int CW         = $clog2(NBANK > WIDE_WORDS ? NBANK : WIDE_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_n,
  input  logic          pause,
  input  logic [DW-1:0] din,
  output logic          take_data,
  output logic          last_word,
  output logic [CW-1:0] slot,
  output logic [2:0]    cls,
  output logic [DW-4:0] idx
);
  import wsl_pkg::*;
  localparam int TW = CW + 1;

  logic          ld_prev, active, need_addr;
  logic [CW-1:0] cnt;
  logic [TW-1:0] total;
  logic          session, take;

  assign session   = !ld_n && (active || ld_prev);
  assign take      = session && !pause;
  assign take_data = take && !need_addr;
  assign last_word = (TW'(cnt) + TW'(1)) == total;
  assign slot      = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_prev   <= 1'b0;
      active    <= 1'b0;
      need_addr <= 1'b1;
      cnt       <= '0;
      total     <= TW'(1);
      cls       <= '0;
      idx       <= '0;
    end else begin
      ld_prev <= ld_n;
      active  <= session;
      if (ld_n) begin
        need_addr <= 1'b1;
        cnt       <= '0;
      end else if (take) begin
        if (need_addr) begin
          cls       <= din[DW-1 -: 3];
          idx       <= din[DW-4:0];
          total     <= TW'(data_words(din[DW-1 -: 3], NBANK, WIDE_WORDS));
          cnt       <= '0;
          need_addr <= 1'b0;
        end else if (last_word) begin
          need_addr <= 1'b1;
          cnt       <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wsl_stage.sv
`timescale 1ns/1ps
module wsl_stage #(
  parameter int SLOT_W = 12,
  parameter int SLOTS  = 8,
  parameter int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [SW-1:0]           slot,
  input  logic [SLOT_W-1:0]       word,
  output logic [SLOT_W*SLOTS-1:0] merged
);
  logic [SLOT_W*SLOTS-1:0] stage;

  // the current word replaces its slot; other slots keep what was gathered
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign merged[s*SLOT_W +: SLOT_W] =
      (slot == SW'(s)) ? word : stage[s*SLOT_W +: SLOT_W];
  end

  always_ff @(posedge clk) begin
    if (rst)     stage <= '0;
    else if (en) stage <= merged;
  end
endmodule

// File: rtl/wsl_commit.sv
`timescale 1ns/1ps
module wsl_commit #(
  parameter int DW    = 12,
  parameter int NBANK = 8,
  parameter int ROW_W = 8,
  parameter int CFG_W = 2,
  parameter int REG_W = 4,
  parameter int SELW  = 5,
  parameter int RW    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fire,
  input  logic [2:0]             cls,
  input  logic [DW-4:0]          idx,
  input  logic [DW-1:0]          din,
  input  logic [NBANK*DW-1:0]    coef_in,
  input  logic [RW-1:0]          wide_in,
  output logic                   coef_we,
  output logic [ROW_W-1:0]       coef_row,
  output logic [NBANK*DW-1:0]    coef_data,
  output logic                   cfg_we,
  output logic [CFG_W-1:0]       cfg_idx,
  output logic [DW-1:0]          cfg_data,
  output logic                   sel_we,
  output logic [REG_W-1:0]       sel_idx,
  output logic [SELW-1:0]        sel_data,
  output logic                   rnd_we,
  output logic [REG_W-1:0]       rnd_idx,
  output logic [RW-1:0]          rnd_data,
  output logic                   lim_we,
  output logic [REG_W-1:0]       lim_idx,
  output logic [RW-1:0]          lim_data
);
  import wsl_pkg::*;

  logic unused_idx;
  assign unused_idx = ^idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      coef_we <= 1'b0; coef_row <= '0; coef_data <= '0;
      cfg_we  <= 1'b0; cfg_idx  <= '0; cfg_data  <= '0;
      sel_we  <= 1'b0; sel_idx  <= '0; sel_data  <= '0;
      rnd_we  <= 1'b0; rnd_idx  <= '0; rnd_data  <= '0;
      lim_we  <= 1'b0; lim_idx  <= '0; lim_data  <= '0;
    end else begin
      coef_we <= 1'b0;
      cfg_we  <= 1'b0;
      sel_we  <= 1'b0;
      rnd_we  <= 1'b0;
      lim_we  <= 1'b0;
      if (fire) begin
        case (cls)
          CLS_COEF: begin
            coef_we <= 1'b1; coef_row <= idx[ROW_W-1:0]; coef_data <= coef_in;
          end
          CLS_CFG: begin
            cfg_we <= 1'b1; cfg_idx <= idx[CFG_W-1:0]; cfg_data <= din;
          end
          CLS_SEL: begin
            sel_we <= 1'b1; sel_idx <= idx[REG_W-1:0]; sel_data <= din[SELW-1:0];
          end
          CLS_RND: begin
            rnd_we <= 1'b1; rnd_idx <= idx[REG_W-1:0]; rnd_data <= wide_in;
          end
          CLS_LIM: begin
            lim_we <= 1'b1; lim_idx <= idx[REG_W-1:0]; lim_data <= wide_in;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wordser_loader.sv
`timescale 1ns/1ps
module wordser_loader #(
  parameter int DW    = 12,
  parameter int NBANK = 8,
  parameter int ROWS  = 256,
  parameter int NCFG  = 4,
  parameter int NREG  = 16,
  parameter int SELW  = 5,
  parameter int RW    = 32,
  parameter int BYTE  = 8,
  localparam int ROW_W      = $clog2(ROWS),
  localparam int CFG_W      = $clog2(NCFG),
  localparam int REG_W      = $clog2(NREG),
  localparam int WIDE_WORDS = RW / BYTE,
  localparam int CW         = $clog2(NBANK > WIDE_WORDS ? NBANK : WIDE_WORDS),
  localparam int WSW        = $clog2(WIDE_WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_n,
  input  logic                pause,
  input  logic [DW-1:0]       din,
  output logic                coef_we,
  output logic [ROW_W-1:0]    coef_row,
  output logic [NBANK*DW-1:0] coef_data,
  output logic                cfg_we,
  output logic [CFG_W-1:0]    cfg_idx,
  output logic [DW-1:0]       cfg_data,
  output logic                sel_we,
  output logic [REG_W-1:0]    sel_idx,
  output logic [SELW-1:0]     sel_data,
  output logic                rnd_we,
  output logic [REG_W-1:0]    rnd_idx,
  output logic [RW-1:0]       rnd_data,
  output logic                lim_we,
  output logic [REG_W-1:0]    lim_idx,
  output logic [RW-1:0]       lim_data
);
  import wsl_pkg::*;

  logic                take_data, last_word;
  logic [CW-1:0]       slot;
  logic [2:0]          cls;
  logic [DW-4:0]       idx;
  logic [NBANK*DW-1:0] coef_merged;
  logic [RW-1:0]       wide_merged;
  logic                coef_en, wide_en;

  assign coef_en = take_data && (cls == CLS_COEF);
  assign wide_en = take_data && (cls == CLS_RND || cls == CLS_LIM);

  wsl_seq #(.DW(DW), .NBANK(NBANK), .WIDE_WORDS(WIDE_WORDS), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .ld_n(ld_n), .pause(pause), .din(din),
    .take_data(take_data), .last_word(last_word), .slot(slot),
    .cls(cls), .idx(idx)
  );

  wsl_stage #(.SLOT_W(DW), .SLOTS(NBANK), .SW(CW)) u_coef_stage (
    .clk(clk), .rst(rst), .en(coef_en), .slot(slot), .word(din),
    .merged(coef_merged)
  );

  wsl_stage #(.SLOT_W(BYTE), .SLOTS(WIDE_WORDS), .SW(WSW)) u_wide_stage (
    .clk(clk), .rst(rst), .en(wide_en), .slot(slot[WSW-1:0]),
    .word(din[BYTE-1:0]), .merged(wide_merged)
  );

  wsl_commit #(.DW(DW), .NBANK(NBANK), .ROW_W(ROW_W), .CFG_W(CFG_W),
               .REG_W(REG_W), .SELW(SELW), .RW(RW)) u_commit (
    .clk(clk), .rst(rst), .fire(take_data && last_word), .cls(cls),
    .idx(idx), .din(din), .coef_in(coef_merged), .wide_in(wide_merged),
    .coef_we(coef_we), .coef_row(coef_row), .coef_data(coef_data),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .sel_we(sel_we), .sel_idx(sel_idx), .sel_data(sel_data),
    .rnd_we(rnd_we), .rnd_idx(rnd_idx), .rnd_data(rnd_data),
    .lim_we(lim_we), .lim_idx(lim_idx), .lim_data(lim_data)
  );
endmodule

// File: rtl/wordser_loader_chk.sv
`timescale 1ns/1ps
module wordser_loader_chk (
  input logic clk,
  input logic rst,
  input logic ld_n,
  input logic pause,
  input logic coef_we,
  input logic cfg_we,
  input logic sel_we,
  input logic rnd_we,
  input logic lim_we
);
  logic any_we;
  assign any_we = coef_we | cfg_we | sel_we | rnd_we | lim_we;

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({coef_we, cfg_we, sel_we, rnd_we, lim_we}));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    any_we |=> !any_we);

  // R8
  pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pause |=> !any_we);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ld_n |=> !any_we);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !any_we);
endmodule

bind wordser_loader wordser_loader_chk u_chk (
  .clk(clk), .rst(rst), .ld_n(ld_n), .pause(pause),
  .coef_we(coef_we), .cfg_we(cfg_we), .sel_we(sel_we),
  .rnd_we(rnd_we), .lim_we(lim_we)
);

// File: tb/sim_wordser_loader.sv
`timescale 1ns/1ps
module sim_wordser_loader;
  logic clk = 1'b0, rst = 1'b1, ld_n = 1'b0, pause = 1'b0;
  logic [11:0] din = '0;
  logic        coef_we, cfg_we, sel_we, rnd_we, lim_we;
  logic [7:0]  coef_row;
  logic [95:0] coef_data;
  logic [1:0]  cfg_idx;
  logic [11:0] cfg_data;
  logic [3:0]  sel_idx, rnd_idx, lim_idx;
  logic [4:0]  sel_data;
  logic [31:0] rnd_data, lim_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wordser_loader u0 (
    .clk(clk), .rst(rst), .ld_n(ld_n), .pause(pause), .din(din),
    .coef_we(coef_we), .coef_row(coef_row), .coef_data(coef_data),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .sel_we(sel_we), .sel_idx(sel_idx), .sel_data(sel_data),
    .rnd_we(rnd_we), .rnd_idx(rnd_idx), .rnd_data(rnd_data),
    .lim_we(lim_we), .lim_idx(lim_idx), .lim_data(lim_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    logic [4:0] w;
    w = {coef_we, cfg_we, sel_we, rnd_we, lim_we};
    chk(w == 5'b0, req, "no write strobe", 96'(w), 96'(0));
  endtask

  task automatic put(input logic [11:0] w);
    ld_n = 1'b0; pause = 1'b0; din = w;
    @(posedge clk); #1;
  endtask

  task automatic hold_word(input logic [11:0] w);
    ld_n = 1'b0; pause = 1'b1; din = w;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      ld_n = 1'b1; pause = 1'b0; din = 12'hFFF;
      @(posedge clk); #1;
    end
  endtask

  function automatic logic [11:0] cval(input int row, input int k);
    return 12'(row * 53 + k * 311 + 7);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R6 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [95:0] exp_coef;
    logic [31:0] val;
    logic [4:0]  v;

    rst = 1'b1; ld_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    chk(coef_data == 0 && rnd_data == 0 && lim_data == 0 && cfg_data == 0,
        "R1", "data outputs after reset", {coef_data[63:0], rnd_data}, 96'(0));
    quiet("R1");
    // R1: ld_n low straight from reset must not open a session
    put(12'h201); quiet("R1");
    put(12'h0AB); quiet("R1");
    put(12'h0CD); quiet("R1");
    chk(cfg_data == 0, "R1", "cfg_data untouched", 96'(cfg_data), 96'(0));
    idle(2);

    // R2 R3 R7: every coefficient row, back to back in one session
    for (int row = 0; row < 256; row++) begin
      put(12'(row));
      for (int k = 0; k < 8; k++) begin
        put(cval(row, k));
        if (k < 7 && row < 4) quiet("R6");
        exp_coef[k*12 +: 12] = cval(row, k);
      end
      chk(coef_we == 1'b1, "R3", "coef_we after 8th word", 96'(coef_we), 96'(1));
      chk(coef_row == 8'(row), "R2", "coef_row", 96'(coef_row), 96'(row));
      chk(coef_data == exp_coef, "R3", "coef_data", coef_data, exp_coef);
    end
    put(12'h0F0);
    chk(coef_we == 1'b0 && coef_row == 8'd255, "R11", "coef strobe one cycle, row held",
        {coef_we, coef_row}, {1'b0, 8'd255});
    idle(1);

    // R10: unused classes consume one data word, then a cfg write follows
    for (int c = 2; c <= 6; c += 2) begin
      put({3'(c), 9'h015}); quiet("R10");
      put(12'h3FF);         quiet("R10");
      put(12'h200 | 12'(c >> 1));
      put(12'(c * 111));
      chk(cfg_we == 1'b1 && cfg_idx == 2'(c >> 1) && cfg_data == 12'(c * 111),
          "R10", "cfg write after unused class", {cfg_we, cfg_idx, cfg_data},
          {1'b1, 2'(c >> 1), 12'(c * 111)});
    end

    // R4: configuration registers
    for (int i = 0; i < 4; i++) begin
      put(12'h200 | 12'(i));
      put(12'hC00 | 12'(i * 37));
      chk(cfg_we && cfg_idx == 2'(i) && cfg_data == (12'hC00 | 12'(i * 37)),
          "R4", "cfg write", {cfg_we, cfg_idx, cfg_data},
          {1'b1, 2'(i), 12'hC00 | 12'(i * 37)});
    end
    // R4: select registers, upper word bits set and dropped
    for (int i = 0; i < 16; i++) begin
      v = 5'(i * 7 + 3);
      put(12'h600 | 12'(i));
      put(12'hFE0 | 12'(v));
      chk(sel_we && sel_idx == 4'(i) && sel_data == v, "R4", "select write",
          {sel_we, sel_idx, sel_data}, {1'b1, 4'(i), v});
    end
    idle(1);
    chk(!sel_we && sel_data == 5'(15 * 7 + 3), "R11", "select value held",
        {sel_we, sel_data}, {1'b0, 5'(15 * 7 + 3)});

    // R5: round registers, bytes low first, reserved nibble set
    for (int i = 0; i < 16; i++) begin
      val = 32'h9E3779B9 * 32'(i + 1);
      put(12'hA00 | 12'(i));
      for (int j = 0; j < 4; j++) begin
        put({4'hF, val[j*8 +: 8]});
        if (j < 3 && i < 2) quiet("R6");
      end
      chk(rnd_we && rnd_idx == 4'(i) && rnd_data == val, "R5", "round write",
          {rnd_we, rnd_idx, rnd_data}, {1'b1, 4'(i), val});
    end
    // R5: limit registers, upper bound in 31:16, lower in 15:0
    for (int i = 0; i < 16; i++) begin
      val = {16'(i * 2221 + 40000), 16'(i * 4099 + 17)};
      put(12'hE00 | 12'(i));
      for (int j = 0; j < 4; j++) put({4'hA, val[j*8 +: 8]});
      chk(lim_we && lim_idx == 4'(i) && lim_data == val, "R5", "limit write",
          {lim_we, lim_idx, lim_data}, {1'b1, 4'(i), val});
    end
    idle(2);

    // R8: pause on the opening edge and between every word
    val = 32'h7683F4A2;
    hold_word(12'h0FF); quiet("R8");
    put(12'hA07);
    for (int j = 0; j < 4; j++) begin
      hold_word(12'h555); quiet("R8");
      hold_word(12'h0AA); quiet("R8");
      put({4'h0, val[j*8 +: 8]});
    end
    chk(rnd_we && rnd_idx == 4'd7 && rnd_data == val, "R8", "round write across pauses",
        {rnd_we, rnd_idx, rnd_data}, {1'b1, 4'd7, val});
    idle(1);

    // R9: abandon a partial coefficient set, restart with a select write
    put(12'h010); put(12'h001); put(12'h002); put(12'h003);
    idle(1); quiet("R9");
    put(12'h602);
    quiet("R9");
    put(12'h011);
    chk(sel_we && sel_idx == 4'd2 && sel_data == 5'h11 && !coef_we, "R9",
        "fresh address after abandon", {coef_we, sel_we, sel_idx, sel_data},
        {1'b0, 1'b1, 4'd2, 5'h11});
    idle(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule